// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits beside a bridge from a system interconnect to a peripheral bus and decides which peripheral region a transaction address belongs to. It holds a small array of address windows. Each window is described by a control word (an enable, an 8-bit target attribute and a size mask) and a base word. Software reads and writes both words through a simple 32-bit register port with byte offsets.

Every address presented with its valid strobe is compared in parallel against all enabled windows. Bits covered by a window's size mask are left out of the comparison. One cycle later the block reports a hit, the index of the winning window and that window's target attribute. When more than one window matches, the lowest index wins and a multi-hit flag is raised. When none matches, a miss flag is raised. A window's settings are only honoured once its enable bit is written as one. Software can therefore clear every enable, reprogram the windows, and then switch them back on.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every control and base register reads as zero, and a valid address produces a miss with no hit.
- R2: A window whose control bit 0 (enable) is clear never produces a hit, whatever its base, size or attribute. Clearing the enable of a matching window makes the next decode skip it.
- R3: On a hit, the result attribute equals control bits [15:8] of the winning window.
- R4: Control bits [23:16] form the size field, counting 64KB blocks minus one as a run of ones from address bit 16 upward. Address bits [23:16] under a one in the size field are ignored in the compare, and address bits [15:0] are always ignored. A size of 0 gives a 64KB window, and a size of 0x0F gives a 1MB window.
- R5: Window n has its control register at byte offset 8n and its base register at 8n+4. The base register keeps only bits [31:16], so its bits [15:0] read as zero. The control register keeps only bits 0, [15:8] and [23:16], so all other bits read as zero.
- R6: When several enabled windows match, the reported index is the lowest matching index.
- R7: The multi-hit flag is set exactly when two or more windows match. The miss flag is set exactly when a valid address matches no window.
- R8: Results appear on the clock edge after the address is presented with its valid strobe asserted, and the result-valid output follows that strobe. Without the strobe, hit, miss and multi-hit are all zero. On a miss, index and attribute are zero.
- R9: Writes to byte offsets at or beyond 8 × (number of windows) change no window, and reads from those offsets return zero.
- R10: A register write takes effect for addresses presented in the cycles after it. An address presented in the same cycle as the enabling write is decoded with the old, disabled settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dec_valid | input | 1 | Transaction address valid |
| dec_addr | input | 32 | Transaction address |
| res_valid | output | 1 | Decode result valid |
| res_hit | output | 1 | Address matched an enabled window |
| res_miss | output | 1 | Address matched no enabled window |
| res_multi | output | 1 | Two or more windows matched |
| res_idx | output | 3 | Index of the winning window |
| res_attr | output | 8 | Target attribute of the winning window |

## Verification
The assertions check the following on every cycle:
- the chosen window really matched and is the lowest match;
- the chosen window is enabled;
- multi-hit implies hit;
- the result is quiet when no address was valid;
- the result timing follows the valid strobe.

Only the bench's scenarios can show the rest:
- the masked-compare arithmetic at window edges for different size fields;
- the register field layout and which bits read back as zero;
- the ignored out-of-range offsets;
- the one-cycle gap between an enabling write and its effect on decode.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
    localparam int DATA_W   = 32;
    localparam int ATTR_W   = 8;
    localparam int SIZE_W   = 8;
    localparam int BASE_W   = 16;
    localparam int EN_BIT   = 0;
    localparam int ATTR_LSB = 8;
    localparam int SIZE_LSB = 16;
    localparam int BASE_LSB = 16;

    typedef struct packed {
        logic              en;
        logic [ATTR_W-1:0] attr;
        logic [SIZE_W-1:0] size;
        logic [BASE_W-1:0] base;
    } win_cfg_t;
endpackage

// File: rtl/win_regfile.sv
module win_regfile
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]    cfg
);
    localparam int SEL_W = REG_AW - 3;

    win_cfg_t [NUM_WIN-1:0] cfg_d, cfg_q;
    logic [SEL_W-1:0]       win_sel;
    logic                   is_base;
    logic                   unused_bits;

    assign win_sel     = reg_addr[REG_AW-1:3];
    assign is_base     = reg_addr[2];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:24], reg_wdata[7:1], reg_wdata[15:0]};

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_wr && (int'(win_sel) == i)) begin
                if (is_base) begin
                    cfg_d[i].base = reg_wdata[BASE_LSB +: BASE_W];
                end else begin
                    cfg_d[i].en   = reg_wdata[EN_BIT];
                    cfg_d[i].attr = reg_wdata[ATTR_LSB +: ATTR_W];
                    cfg_d[i].size = reg_wdata[SIZE_LSB +: SIZE_W];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (int'(win_sel) == i) begin
                if (is_base) begin
                    reg_rdata[BASE_LSB +: BASE_W] = cfg_q[i].base;
                end else begin
                    reg_rdata[EN_BIT]               = cfg_q[i].en;
                    reg_rdata[ATTR_LSB +: ATTR_W]   = cfg_q[i].attr;
                    reg_rdata[SIZE_LSB +: SIZE_W]   = cfg_q[i].size;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    AST_RESET_DISABLED: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg_q == '0)); // R1
endmodule

// File: rtl/win_match.sv
module win_match
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [BASE_W-1:0]      addr_hi,
    output logic [NUM_WIN-1:0]     hit_vec
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [BASE_W-1:0] care;
        assign care       = ~{{(BASE_W-SIZE_W){1'b0}}, cfg[g].size};
        assign hit_vec[g] = cfg[g].en && (((addr_hi ^ cfg[g].base) & care) == '0);
    end
endmodule

// File: rtl/win_pick.sv
module win_pick #(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hit_vec,
    output logic               any,
    output logic               multi,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end

    assign any   = |hit_vec;
    assign multi = |(hit_vec & (hit_vec - NUM_WIN'(1)));
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int REG_AW   = 8,
    localparam int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dec_valid,
    input  logic [31:0]       dec_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_multi,
    output logic [IDX_W-1:0]  res_idx,
    output logic [ATTR_W-1:0] res_attr
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic              multi;
        logic [IDX_W-1:0]  idx;
        logic [ATTR_W-1:0] attr;
    } result_t;

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hit_vec;
    logic                   pick_any;
    logic                   pick_multi;
    logic [IDX_W-1:0]       pick_idx;
    result_t                res_d, res_q;
    logic                   unused_addr;

    assign unused_addr = ^dec_addr[15:0];

    win_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg     (cfg),
        .addr_hi (dec_addr[31:16]),
        .hit_vec (hit_vec)
    );

    win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hit_vec (hit_vec),
        .any     (pick_any),
        .multi   (pick_multi),
        .idx     (pick_idx)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = dec_valid;
        if (dec_valid) begin
            res_d.hit   = pick_any;
            res_d.miss  = !pick_any;
            res_d.multi = pick_multi;
            if (pick_any) begin
                res_d.idx  = pick_idx;
                res_d.attr = cfg[pick_idx].attr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_miss  = res_q.miss;
    assign res_multi = res_q.multi;
    assign res_idx   = res_q.idx;
    assign res_attr  = res_q.attr;

    AST_PICK_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> hit_vec[pick_idx]); // R6
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> ((hit_vec & ((NUM_WIN'(1) << pick_idx) - NUM_WIN'(1))) == '0)); // R6
    AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> cfg[pick_idx].en); // R2
    AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_multi |-> res_hit); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss || res_multi)); // R8
    AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> res_valid); // R8
endmodule

// File: tb/sim_addr_window_decoder.sv
`timescale 1ns/1ps
module sim_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_addr = '0;
    logic        res_valid, res_hit, res_miss, res_multi;
    logic [2:0]  res_idx;
    logic [7:0]  res_attr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    addr_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_valid(dec_valid),
        .dec_addr(dec_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss(res_miss), .res_multi(res_multi), .res_idx(res_idx),
        .res_attr(res_attr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, "rdata", reg_rdata, exp);
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic exp_hit,
                         input logic [2:0] exp_idx, input logic [7:0] exp_attr, input logic exp_multi);
        @(negedge clk);
        dec_valid = 1'b1; dec_addr = a;
        @(negedge clk);
        dec_valid = 1'b0;
        chk(req, "valid", res_valid, 1);
        chk(req, "hit", res_hit, exp_hit);
        chk(req, "miss", res_miss, !exp_hit);
        chk(req, "idx", res_idx, exp_idx);
        chk(req, "attr", res_attr, exp_attr);
        chk(req, "multi", res_multi, exp_multi);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) rd_chk("R1", 8'(i * 4), 0);
        probe("R1", 32'h0000_0000, 0, 0, 0, 0);
    endtask

    task automatic t_readback();
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk("R5", 8'h18, 32'h00FF_FF01);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R5", 8'h1C, 32'hFFFF_0000);
        wr(8'h18, 0);
        wr(8'h1C, 0);
        rd_chk("R5", 8'h18, 0);
    endtask

    task automatic t_one_meg();
        wr(8'h04, 32'h1000_0000);
        wr(8'h00, 32'h000F_5A00);
        probe("R10", 32'h1003_0000, 0, 0, 0, 0);
        wr(8'h00, 32'h000F_5A01);
        probe("R4", 32'h100F_FFFC, 1, 0, 8'h5A, 0);
        probe("R3", 32'h1000_0000, 1, 0, 8'h5A, 0);
        probe("R4", 32'h1010_0000, 0, 0, 0, 0);
        probe("R4", 32'h0FFF_FFFC, 0, 0, 0, 0);
    endtask

    task automatic t_size_zero();
        wr(8'h14, 32'h2000_0000);
        wr(8'h10, 32'h0000_2201);
        probe("R4", 32'h2000_FFFF, 1, 2, 8'h22, 0);
        probe("R4", 32'h2001_0000, 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        wr(8'h2C, 32'h1000_0000);
        wr(8'h28, 32'h0000_5501);
        probe("R6", 32'h1000_1234, 1, 0, 8'h5A, 1);
        wr(8'h00, 32'h000F_5A00);
        probe("R2", 32'h1000_1234, 1, 5, 8'h55, 0);
        probe("R7", 32'h1002_0000, 0, 0, 0, 0);
    endtask

    task automatic t_out_of_range();
        wr(8'h40, 32'h00FF_AA01);
        wr(8'h44, 32'h3000_0000);
        wr(8'h7C, 32'hFFFF_FFFF);
        rd_chk("R9", 8'h40, 0);
        rd_chk("R9", 8'h44, 0);
        rd_chk("R9", 8'h7C, 0);
        rd_chk("R9", 8'h00, 32'h000F_5A00);
        rd_chk("R9", 8'h38, 0);
        probe("R9", 32'h3000_0000, 0, 0, 0, 0);
    endtask

    task automatic t_no_valid();
        @(negedge clk);
        dec_valid = 1'b0; dec_addr = 32'h1000_1234;
        @(negedge clk);
        chk("R8", "valid", res_valid, 0);
        chk("R8", "hit", res_hit, 0);
        chk("R8", "miss", res_miss, 0);
        chk("R8", "multi", res_multi, 0);
    endtask

    task automatic t_same_cycle();
        wr(8'h34, 32'h4000_0000);
        wr(8'h30, 32'h0000_6600);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h0000_6601;
        dec_valid = 1'b1; dec_addr = 32'h4000_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R10", "hit same cycle", res_hit, 0);
        chk("R10", "miss same cycle", res_miss, 1);
        @(negedge clk);
        dec_valid = 1'b0;
        chk("R10", "hit next cycle", res_hit, 1);
        chk("R10", "idx next cycle", res_idx, 6);
        chk("R10", "attr next cycle", res_attr, 8'h66);
    endtask

    task automatic t_disable_all();
        for (int i = 0; i < 8; i++) wr(8'(i * 8), 0);
        probe("R2", 32'h1000_1234, 0, 0, 0, 0);
        probe("R2", 32'h4000_0000, 0, 0, 0, 0);
        probe("R2", 32'h2000_0000, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_one_meg();
        t_size_zero();
        t_priority();
        t_out_of_range();
        t_no_valid();
        t_same_cycle();
        t_disable_all();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule